// File: doc/BRIEF.md
# Thermal Hysteresis Fan PWM Controller

The block drives a fan through a single pulse-width-modulated output whose period is a fixed number of clock cycles. The duty cycle follows a five-level ladder (0%, 25%, 50%, 75% and 100%). Each temperature sample moves the ladder up or down by one rung. Every rung has its own upward and downward threshold, so the level holds while the temperature sits between the two.

Software reaches the block through a small word-wide register port:
- a run bit that holds the block in soft reset while it is low;
- a pulse-width register that can be read and written, so software can force a duty the ladder does not contain;
- a read-only period register;
- eight threshold registers.

Two one-cycle strobes go to an interrupt controller. One marks a rise of the ladder caused by temperature. The other marks that the fan has had a fixed settling time after the most recent duty change.

Top module: `fan_pwm_ctrl`

## Requirements
- R1: The PWM period is PERIOD cycles. Once running, a cycle counter starts at 0 and wraps at PERIOD-1. `pwm_o` is high while the counter is below the current width, so it is always high when width >= PERIOD. Address 2 reads PERIOD, which is never zero.
- R2: After `rst_ni`, and in every cycle in which run bit 0 of address 0 is clear:
  - `pwm_o` is low, and no strobe fires;
  - the level is forced to 100% and the width to PERIOD;
  - writes to the width register are ignored.
  The block starts running in the cycle after bit 0 is written as 1.
- R3: An automatic change to level k (0..4) loads the width with floor(k*PERIOD/4).
- R4: When `temp_valid_i` is high and the level k is below 4, the level rises one step if `temp_i` is strictly above the rise threshold at address 8+k. It never moves more than one step per sample.
- R5: When no rise applies and the level k is above 0, the level falls one step if `temp_i` is strictly below the fall threshold at address 12+k-1. A sample equal to either threshold, or between them, holds the level.
- R6: `temp_up_o` is high for exactly the one cycle in which the width register first shows an automatic rise, and never on a fall or a software write.
- R7: `pwm_changed_o` pulses once, SETTLE cycles after the edge of the most recent duty change, where SETTLE = CLK_HZ/1000*SETTLE_MS. A duty change is any automatic level change or any write to address 1. A new change inside the window restarts the wait.
- R8: A write to address 1 while running loads the width directly and reads back unchanged. It wins over an automatic change in the same cycle, whose level still moves. It starts the settle wait and raises no `temp_up_o`.
- R9: After `rst_ni` the rise thresholds (addresses 8..11) read 0xFFFF and the fall thresholds (addresses 12..15) read 0x0000. All threshold registers are writable at any time and read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Register read data (combinational from address) |
| temp_i | input | DW | Raw temperature code, unsigned |
| temp_valid_i | input | 1 | Temperature sample strobe |
| pwm_o | output | 1 | Fan PWM output |
| temp_up_o | output | 1 | Strobe: level raised by temperature |
| pwm_changed_o | output | 1 | Strobe: settle time elapsed after a duty change |

## Verification
A sample or write presented in one cycle is registered at the next rising edge:
- The new level, the width and `temp_up_o` all appear right after that edge.
- `pwm_o` reflects the new width from that same cycle.
- `pwm_changed_o` appears SETTLE edges later.

The bench drives inputs on falling edges. Its reference model advances on each rising edge from the inputs and its own state. On every falling edge it compares all three outputs with the model. Register reads are sampled just after the falling edge, once the new address has settled.

// File: rtl/fan_pwm_pkg.sv
package fan_pwm_pkg;
  typedef logic [2:0] lvl_t;
  localparam lvl_t LVL_MAX = 3'd4;

  localparam logic [3:0] A_CTRL   = 4'd0;
  localparam logic [3:0] A_WIDTH  = 4'd1;
  localparam logic [3:0] A_PERIOD = 4'd2;
  // rise thresholds at 8..11, fall thresholds at 12..15; bit 2 picks the set
  localparam logic [1:0] A_THR_HI = 2'b10;
endpackage

// File: rtl/fan_level_fsm.sv
module fan_level_fsm
  import fan_pwm_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 eval_i,
  input  logic [DW-1:0]        temp_i,
  input  logic [3:0][DW-1:0]   rise_i,
  input  logic [3:0][DW-1:0]   fall_i,
  output lvl_t                 lvl_d_o,
  output logic                 move_o,
  output logic                 up_o
);
  lvl_t lvl_q, lvl_d;
  logic up_q;
  logic [1:0] dn_idx;

  assign dn_idx = 2'(lvl_q - 3'd1);

  always_comb begin
    lvl_d = lvl_q;
    if (eval_i) begin
      if (lvl_q != LVL_MAX && temp_i > rise_i[lvl_q[1:0]])
        lvl_d = lvl_q + 3'd1;
      else if (lvl_q != 3'd0 && temp_i < fall_i[dn_idx])
        lvl_d = lvl_q - 3'd1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= LVL_MAX;
      up_q  <= 1'b0;
    end else if (clr_i) begin
      lvl_q <= LVL_MAX;
      up_q  <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
      up_q  <= lvl_d > lvl_q;
    end
  end

  assign lvl_d_o = lvl_d;
  assign move_o  = lvl_d != lvl_q;
  assign up_o    = up_q;

  p_one_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(clr_i) |-> (lvl_q == $past(lvl_q)) || (lvl_q == $past(lvl_q) + 3'd1)
                      || ($past(lvl_q) == lvl_q + 3'd1));

  p_up_on_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_o |-> lvl_q == $past(lvl_q) + 3'd1);
endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen #(
  parameter int DW     = 16,
  parameter int PERIOD = 1000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [DW-1:0] width_i,
  output logic          pwm_o
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (cnt_q == CNT_LAST) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  assign pwm_o = !clr_i && (DW'(cnt_q) < width_i);

  p_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cnt_q) == CNT_LAST) |-> cnt_q == '0);
endmodule

// File: rtl/fan_settle_timer.sv
module fan_settle_timer #(
  parameter int CYC = 250_000_000  // must be >= 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic start_i,
  output logic done_o
);
  localparam int TW = $clog2(CYC + 1);

  logic [TW-1:0] tmr_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q  <= '0;
      done_q <= 1'b0;
    end else if (clr_i) begin
      tmr_q  <= '0;
      done_q <= 1'b0;
    end else if (start_i) begin
      tmr_q  <= TW'(CYC);
      done_q <= 1'b0;
    end else if (tmr_q != '0) begin
      tmr_q  <= tmr_q - 1'b1;
      done_q <= tmr_q == TW'(1);
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o = done_q;

  p_single_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_quiet_before_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !$past(start_i));
endmodule

// File: rtl/fan_pwm_ctrl.sv
module fan_pwm_ctrl
  import fan_pwm_pkg::*;
#(
  parameter int DW        = 16,
  parameter int PERIOD    = 1000,
  parameter int CLK_HZ    = 50_000_000,
  parameter int SETTLE_MS = 5000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [3:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic [DW-1:0] temp_i,
  input  logic          temp_valid_i,
  output logic          pwm_o,
  output logic          temp_up_o,
  output logic          pwm_changed_o
);
  localparam int SETTLE = CLK_HZ / 1000 * SETTLE_MS;
  localparam logic [DW-1:0] PERIOD_W = DW'(PERIOD);

  logic                run_q;
  logic [DW-1:0]       width_q;
  logic [3:0][DW-1:0]  rise_q, fall_q;
  lvl_t                lvl_d;
  logic                move, sw_wr, clr;

  function automatic logic [DW-1:0] lvl_width(lvl_t k);
    return DW'((PERIOD * int'(k)) / 4);
  endfunction

  assign clr   = !run_q;
  assign sw_wr = reg_we_i && reg_addr_i == A_WIDTH;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      rise_q <= '1;
      fall_q <= '0;
    end else if (reg_we_i) begin
      if (reg_addr_i == A_CTRL) run_q <= reg_wdata_i[0];
      if (reg_addr_i[3:2] == A_THR_HI) rise_q[reg_addr_i[1:0]] <= reg_wdata_i;
      if (reg_addr_i[3:2] == 2'b11)    fall_q[reg_addr_i[1:0]] <= reg_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    width_q <= PERIOD_W;
    else if (clr)   width_q <= PERIOD_W;
    else if (sw_wr) width_q <= reg_wdata_i;
    else if (move)  width_q <= lvl_width(lvl_d);
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i[3:2])
      2'b00: begin
        if (reg_addr_i == A_CTRL)   reg_rdata_o = DW'(run_q);
        if (reg_addr_i == A_WIDTH)  reg_rdata_o = width_q;
        if (reg_addr_i == A_PERIOD) reg_rdata_o = PERIOD_W;
      end
      2'b10:   reg_rdata_o = rise_q[reg_addr_i[1:0]];
      2'b11:   reg_rdata_o = fall_q[reg_addr_i[1:0]];
      default: reg_rdata_o = '0;
    endcase
  end

  fan_level_fsm #(.DW(DW)) u_lvl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .eval_i  (run_q && temp_valid_i),
    .temp_i  (temp_i),
    .rise_i  (rise_q),
    .fall_i  (fall_q),
    .lvl_d_o (lvl_d),
    .move_o  (move),
    .up_o    (temp_up_o)
  );

  fan_pwm_gen #(.DW(DW), .PERIOD(PERIOD)) u_pwm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .width_i (width_q),
    .pwm_o   (pwm_o)
  );

  fan_settle_timer #(.CYC(SETTLE)) u_settle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .start_i (sw_wr || move),
    .done_o  (pwm_changed_o)
  );

  p_hold_full_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!run_q) |-> (width_q == PERIOD_W) && !temp_up_o && !pwm_changed_o);

  p_period_nonzero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == A_PERIOD) |-> reg_rdata_o != '0);

  p_sw_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(run_q && sw_wr) |-> width_q == $past(reg_wdata_i));
endmodule

// File: tb/tb_fan_pwm_ctrl.sv
module tb_fan_pwm_ctrl;
  localparam int DW = 16;
  localparam int P  = 8;
  localparam int SC = 20;  // CLK_HZ/1000*SETTLE_MS below

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0, t_valid = 1'b0;
  logic [3:0] addr = '0;
  logic [DW-1:0] wdata = '0, temp = '0, rdata;
  logic pwm, t_up, p_chg;

  fan_pwm_ctrl #(.DW(DW), .PERIOD(P), .CLK_HZ(1000), .SETTLE_MS(SC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .temp_i(temp),
    .temp_valid_i(t_valid), .pwm_o(pwm), .temp_up_o(t_up), .pwm_changed_o(p_chg));

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0, chg_seen = 0, hi_cnt = 0;
  bit done = 0;

  // reference model
  bit m_run, m_up, m_chg;
  int m_level, m_width, m_cnt, m_tmr, nl, nw;
  bit restart;
  int m_rise[4], m_fall[4];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_level = 4; m_width = P; m_cnt = 0; m_tmr = 0; m_chg = 0; m_up = 0;
      foreach (m_rise[i]) begin m_rise[i] = 16'hFFFF; m_fall[i] = 0; end
    end else begin
      if (!m_run) begin
        m_level = 4; m_width = P; m_cnt = 0; m_tmr = 0; m_chg = 0; m_up = 0;
      end else begin
        nl = m_level;
        if (t_valid) begin
          if (m_level < 4 && int'(temp) > m_rise[m_level]) nl = m_level + 1;
          else if (m_level > 0 && int'(temp) < m_fall[m_level-1]) nl = m_level - 1;
        end
        m_up = nl > m_level;
        restart = (nl != m_level);
        nw = m_width;
        if (we && addr == 4'd1) begin nw = int'(wdata); restart = 1; end
        else if (nl != m_level) nw = nl * P / 4;
        m_cnt = (m_cnt == P - 1) ? 0 : m_cnt + 1;
        if (restart) begin m_tmr = SC; m_chg = 0; end
        else if (m_tmr > 0) begin m_chg = (m_tmr == 1); m_tmr--; end
        else m_chg = 0;
        m_level = nl; m_width = nw;
      end
      if (we) begin
        if (addr == 4'd0) m_run = wdata[0];
        if (addr >= 4'd8 && addr <= 4'd11) m_rise[addr-8] = int'(wdata);
        if (addr >= 4'd12) m_fall[addr-12] = int'(wdata);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      automatic bit e_pwm = m_run && (m_cnt < m_width);
      chk(pwm == e_pwm && t_up == m_up && p_chg == m_chg, "R1 R6 R7 model",
          {pwm, t_up, p_chg}, {e_pwm, m_up, m_chg});
      if (p_chg) chg_seen++;
      if (pwm) hi_cnt++;
    end
  end

  task automatic wr(input logic [3:0] a, input int d);
    @(negedge clk); we = 1; addr = a; wdata = DW'(d);
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    @(negedge clk); addr = a; #1; v = int'(rdata);
  endtask

  task automatic smp(input int t);
    @(negedge clk); temp = DW'(t); t_valid = 1;
    @(negedge clk); t_valid = 0;
  endtask

  task automatic finish_run;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state
    rd(4'd0, v);  chk(v == 0, "R2 ctrl after reset", v, 0);
    rd(4'd1, v);  chk(v == P, "R2 width after reset", v, P);
    rd(4'd2, v);  chk(v == P, "R1 period reg", v, P);
    for (int i = 8; i < 12; i++) begin rd(4'(i), v); chk(v == 16'hFFFF, "R9 rise reset", v, 16'hFFFF); end
    for (int i = 12; i < 16; i++) begin rd(4'(i), v); chk(v == 0, "R9 fall reset", v, 0); end
    wr(4'd1, 3); rd(4'd1, v); chk(v == P, "R2 width write ignored in soft reset", v, P);
    hi_cnt = 0; repeat (P) @(negedge clk); chk(hi_cnt == 0, "R2 pwm low in soft reset", hi_cnt, 0);
    // thresholds
    for (int i = 0; i < 4; i++) begin wr(4'(8 + i), 100 * (i + 1)); wr(4'(12 + i), 100 * (i + 1) - 10); end
    rd(4'd10, v); chk(v == 300, "R9 rise readback", v, 300);
    rd(4'd13, v); chk(v == 190, "R9 fall readback", v, 190);
    wr(4'd0, 1);
    // full duty at start
    smp(500); rd(4'd1, v); chk(v == 8, "R4 hold at top", v, 8);
    smp(395); smp(390); rd(4'd1, v); chk(v == 8, "R5 equal fall holds", v, 8);
    smp(389); rd(4'd1, v); chk(v == 6, "R5 fall to 75 R3", v, 6);
    @(negedge clk); hi_cnt = 0; repeat (P) @(negedge clk);
    chk(hi_cnt == 6, "R1 high cycles per period", hi_cnt, 6);
    smp(50); rd(4'd1, v); chk(v == 4, "R5 one step per sample", v, 4);
    smp(50); smp(50); rd(4'd1, v); chk(v == 0, "R3 level 0 width", v, 0);
    smp(50); smp(100); rd(4'd1, v); chk(v == 0, "R4 equal rise holds", v, 0);
    @(negedge clk); temp = 101; t_valid = 1;
    @(negedge clk); t_valid = 0; chk(t_up == 1, "R6 temp_up on rise", t_up, 1);
    rd(4'd1, v); chk(v == 2, "R4 rise to 25", v, 2);
    smp(1000); rd(4'd1, v); chk(v == 4, "R4 rise one step", v, 4);
    wr(4'd1, 3); chk(t_up == 0, "R8 no temp_up on write", t_up, 0);
    rd(4'd1, v); chk(v == 3, "R8 width readback", v, 3);
    // write together with rise
    @(negedge clk); we = 1; addr = 4'd1; wdata = 5; temp = 1000; t_valid = 1;
    @(negedge clk); we = 0; t_valid = 0;
    chk(t_up == 1, "R6 rise with write", t_up, 1);
    rd(4'd1, v); chk(v == 5, "R8 write wins", v, 5);
    smp(1000); rd(4'd1, v); chk(v == 8, "R3 level 4 width", v, 8);
    // settle restart
    repeat (2 * SC) @(negedge clk);
    chg_seen = 0;
    smp(389); repeat (5) @(negedge clk); smp(50);
    repeat (2 * SC) @(negedge clk);
    chk(chg_seen == 1, "R7 restart gives one pulse", chg_seen, 1);
    chg_seen = 0; wr(4'd1, 7); repeat (SC - 2) @(negedge clk);
    chk(chg_seen == 0, "R7 no early pulse", chg_seen, 0);
    repeat (4) @(negedge clk);
    chk(chg_seen == 1, "R7 pulse after settle", chg_seen, 1);
    // back to soft reset
    wr(4'd0, 0); rd(4'd1, v); chk(v == P, "R2 width forced on stop", v, P);
    hi_cnt = 0; repeat (2 * P) @(negedge clk);
    chk(hi_cnt == 0, "R2 pwm low after stop", hi_cnt, 0);
    finish_run();
  end
endmodule